// File: doc/BRIEF.md
# Parity-Based Timing Warning Monitor

This block holds a bank of pipeline data registers and watches them with parity kept per group of four bits. One parity tree per group covers every path that ends in the group. It raises two kinds of flag:

- **Setup warning.** The warning is set when a parity sample taken after an extra delay differs from the parity of the word that was actually loaded. Such a difference means the slack was too thin for that group.
- **Functional error.** The error is set when the bits held in a group no longer match the parity recorded for that group when it was loaded.

The same generator and checker serve both jobs. No separate prediction flop is placed per path. For each group, the block stores one parity bit next to four data bits.

In the surrounding system, the delayed parity sample comes from the analog side through a delay chain. Here it is a plain input, so lateness is modelled by whoever drives that input. The block reports per-group vectors and a one-bit OR summary of each vector. A fault-injection input flips one selected stored bit, so the error path can be exercised. The data width is a parameter and must be a multiple of four. Group k covers bits 4k to 4k+3.

Top module: `par_timing_mon`

## Requirements
- R1: While rst_ni is low, data_o, warn_o, err_o, warn_any_o and err_any_o are all zero.
- R2: A rising edge with cap_en_i high loads data_i into data_o. An edge with cap_en_i and inj_en_i both low leaves data_o unchanged, whatever data_i is.
- R3: After an edge with cap_en_i high, bit k of warn_o equals late_par_i[k] XOR the XOR of data_i bits 4k..4k+3 as sampled at that edge.
- R4: After an edge with cap_en_i low, warn_o is all zero.
- R5: err_o[k] goes high one edge after the bits of group k in data_o stop matching the parity recorded at their capture. It stays high for as long as the mismatch is held.
- R6: An edge with inj_en_i high and cap_en_i low inverts bit inj_idx_i of data_o. When cap_en_i is also high, the injection is ignored: data_o takes data_i and no error follows.
- R7: A capture reloads the recorded parity. From the second edge after a capture without injection, err_o is zero.
- R8: warn_any_o is the OR of warn_o, and err_any_o is the OR of err_o, in the same cycle.
- R9: A warning for a new capture and an error for the contents that capture replaces appear together in the same cycle. Each is reported on its own vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Word to be registered |
| cap_en_i | input | 1 | Load data_i at this edge |
| late_par_i | input | DATA_W/4 | Per-group parity sampled through the added delay |
| inj_en_i | input | 1 | Invert one stored bit at this edge |
| inj_idx_i | input | $clog2(DATA_W) | Index of the bit to invert |
| data_o | output | DATA_W | Registered word |
| warn_o | output | DATA_W/4 | Per-group setup warning |
| err_o | output | DATA_W/4 | Per-group functional error |
| warn_any_o | output | 1 | OR of warn_o |
| err_any_o | output | 1 | OR of err_o |

## Verification
A setup warning and a functional error can share one cycle. This happens because the error check reads the old stored word at the same edge that captures a new word. The bench provokes this by injecting a bit flip and then capturing, on the very next edge, a word whose delayed parity is wrong in chosen groups. It then expects the warning groups to equal that mask, and the error group to be the one that holds the flipped bit. A second overlap, capture and injection on the same edge, is judged by requiring the freshly loaded word with no later error.

// File: rtl/par_timing_pkg.sv
package par_timing_pkg;
  localparam int unsigned GRP_W = 4;

  function automatic logic grp_par(input logic [GRP_W-1:0] bits);
    return ^bits;
  endfunction
endpackage

// File: rtl/par_timing_grp_par.sv
module par_timing_grp_par
  import par_timing_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NGRP  = DATA_W / GRP_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [NGRP-1:0]   par_o
);
  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    assign par_o[k] = grp_par(data_i[k*GRP_W +: GRP_W]);
  end
endmodule

// File: rtl/par_timing_bank.sv
module par_timing_bank
  import par_timing_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NGRP  = DATA_W / GRP_W,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              inj_en_i,
  input  logic [IDX_W-1:0]  inj_idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NGRP-1:0]   gen_par_i,
  output logic [DATA_W-1:0] data_o,
  output logic [NGRP-1:0]   rec_par_o
);
  logic [DATA_W-1:0] data_q, inj_mask;
  logic [NGRP-1:0]   par_q;

  // out-of-range index shifts the one out, leaving an empty mask
  assign inj_mask = DATA_W'(1) << inj_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      par_q  <= '0;
    end else if (cap_en_i) begin
      data_q <= data_i;
      par_q  <= gen_par_i;
    end else if (inj_en_i) begin
      data_q <= data_q ^ inj_mask;
    end
  end

  assign data_o    = data_q;
  assign rec_par_o = par_q;
endmodule

// File: rtl/par_timing_flags.sv
module par_timing_flags
  import par_timing_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NGRP  = DATA_W / GRP_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_en_i,
  input  logic [NGRP-1:0] late_par_i,
  input  logic [NGRP-1:0] gen_par_i,
  input  logic [NGRP-1:0] held_par_i,
  input  logic [NGRP-1:0] rec_par_i,
  output logic [NGRP-1:0] warn_o,
  output logic [NGRP-1:0] err_o
);
  logic [NGRP-1:0] warn_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= '0;
      err_q  <= '0;
    end else begin
      // warning is a per-capture pulse
      warn_q <= cap_en_i ? (late_par_i ^ gen_par_i) : '0;
      // checks the contents held before this edge
      err_q  <= held_par_i ^ rec_par_i;
    end
  end

  assign warn_o = warn_q;
  assign err_o  = err_q;
endmodule

// File: rtl/par_timing_mon.sv
module par_timing_mon
  import par_timing_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NGRP  = DATA_W / GRP_W,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cap_en_i,
  input  logic [NGRP-1:0]   late_par_i,
  input  logic              inj_en_i,
  input  logic [IDX_W-1:0]  inj_idx_i,
  output logic [DATA_W-1:0] data_o,
  output logic [NGRP-1:0]   warn_o,
  output logic [NGRP-1:0]   err_o,
  output logic              warn_any_o,
  output logic              err_any_o
);
  logic [NGRP-1:0] gen_par, held_par, rec_par;

  par_timing_grp_par #(.DATA_W(DATA_W)) u_par_in (
    .data_i (data_i),
    .par_o  (gen_par)
  );

  par_timing_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_i  (cap_en_i),
    .inj_en_i  (inj_en_i),
    .inj_idx_i (inj_idx_i),
    .data_i    (data_i),
    .gen_par_i (gen_par),
    .data_o    (data_o),
    .rec_par_o (rec_par)
  );

  par_timing_grp_par #(.DATA_W(DATA_W)) u_par_held (
    .data_i (data_o),
    .par_o  (held_par)
  );

  par_timing_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (cap_en_i),
    .late_par_i (late_par_i),
    .gen_par_i  (gen_par),
    .held_par_i (held_par),
    .rec_par_i  (rec_par),
    .warn_o     (warn_o),
    .err_o      (err_o)
  );

  assign warn_any_o = |warn_o;
  assign err_any_o  = |err_o;
endmodule

// File: rtl/par_timing_chk.sv
module par_timing_chk
  import par_timing_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NGRP  = DATA_W / GRP_W,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              cap_en_i,
  input logic [NGRP-1:0]   late_par_i,
  input logic              inj_en_i,
  input logic [IDX_W-1:0]  inj_idx_i,
  input logic [DATA_W-1:0] data_o,
  input logic [NGRP-1:0]   warn_o,
  input logic [NGRP-1:0]   err_o,
  input logic              warn_any_o,
  input logic              err_any_o
);
  logic [NGRP-1:0] exp_par;

  always_comb begin
    for (int k = 0; k < NGRP; k++) begin
      exp_par[k] = 1'b0;
      for (int b = 0; b < GRP_W; b++) exp_par[k] = exp_par[k] ^ data_i[k*GRP_W + b];
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (data_o == '0 && warn_o == '0 && err_o == '0
                               && !warn_any_o && !err_any_o);
    end
  end

  // R2
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && !inj_en_i) |=> $stable(data_o));

  // R6
  capture_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> (data_o == $past(data_i)));

  // R3
  warn_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> (warn_o == $past(late_par_i ^ exp_par)));

  // R4
  warn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> (warn_o == '0));

  // R7
  err_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> ##1 (err_o == '0));
endmodule

bind par_timing_mon par_timing_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/par_timing_mon_test.sv
`timescale 1ns/1ps
module par_timing_mon_test;
  localparam int DATA_W = 16;
  localparam int NGRP   = DATA_W / 4;
  localparam int IDX_W  = $clog2(DATA_W);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic [DATA_W-1:0] data_i = '0;
  logic              cap_en_i = 1'b0;
  logic [NGRP-1:0]   late_par_i = '0;
  logic              inj_en_i = 1'b0;
  logic [IDX_W-1:0]  inj_idx_i = '0;
  logic [DATA_W-1:0] data_o;
  logic [NGRP-1:0]   warn_o, err_o;
  logic              warn_any_o, err_any_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  par_timing_mon #(.DATA_W(DATA_W)) uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  function automatic logic [NGRP-1:0] par_of(input logic [DATA_W-1:0] d);
    logic [NGRP-1:0] p;
    for (int k = 0; k < NGRP; k++) p[k] = d[4*k] ^ d[4*k+1] ^ d[4*k+2] ^ d[4*k+3];
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  task automatic chk_zero(input string req);
    chk(data_o == '0, req, data_o, 0);
    chk(warn_o == '0 && err_o == '0, req, {warn_o, err_o}, 0);
    chk(!warn_any_o && !err_any_o, req, {warn_any_o, err_any_o}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] d, d2;
    logic [NGRP-1:0] m, eg;
    #1 rst_ni = 1'b0;
    tick();
    chk_zero("R1 reset");
    @(negedge clk_i) rst_ni = 1'b1;
    #2;

    // R2 R3 R4 R8: capture sweep, every mask pattern on pseudo-random words
    for (int i = 0; i < 1024; i++) begin
      d = next_word();
      m = NGRP'(i);
      data_i = d; cap_en_i = 1'b1; late_par_i = par_of(d) ^ m;
      tick();
      chk(data_o == d, "R2 capture", data_o, d);
      chk(warn_o == m, "R3 warn", warn_o, m);
      chk(warn_any_o == (m != 0), "R8 warn_any", warn_any_o, m != 0);
      if (i % 4 == 3) begin
        cap_en_i = 1'b0; data_i = ~d; late_par_i = ~late_par_i;
        tick();
        chk(data_o == d, "R2 hold", data_o, d);
        chk(warn_o == '0 && !warn_any_o, "R4 warn clear", warn_o, 0);
        chk(err_o == '0 && !err_any_o, "R5 no false error", err_o, 0);
      end
    end

    // R5 R6 R7 R8: inject every bit
    for (int idx = 0; idx < DATA_W; idx++) begin
      d = next_word(); d2 = next_word();
      eg = NGRP'(1) << (idx / 4);
      data_i = d; cap_en_i = 1'b1; late_par_i = par_of(d);
      tick();
      cap_en_i = 1'b0; inj_en_i = 1'b1; inj_idx_i = IDX_W'(idx);
      tick();
      inj_en_i = 1'b0;
      chk(data_o == (d ^ (DATA_W'(1) << idx)), "R6 inject flip", data_o, d ^ (DATA_W'(1) << idx));
      chk(err_o == '0, "R5 error not yet", err_o, 0);
      tick();
      chk(err_o == eg, "R5 error group", err_o, eg);
      chk(err_any_o, "R8 err_any", err_any_o, 1);
      tick();
      chk(err_o == eg, "R5 error held", err_o, eg);
      data_i = d2; cap_en_i = 1'b1; late_par_i = par_of(d2);
      tick();
      cap_en_i = 1'b0;
      chk(err_o == eg, "R5 old contents", err_o, eg);
      tick();
      chk(err_o == '0 && !err_any_o, "R7 error cleared", err_o, 0);
    end

    // R9: warning of new capture with error of replaced contents
    for (int idx = 0; idx < DATA_W; idx++) begin
      d = next_word(); d2 = next_word();
      m = NGRP'(idx + 1);
      eg = NGRP'(1) << (idx / 4);
      data_i = d; cap_en_i = 1'b1; late_par_i = par_of(d);
      tick();
      cap_en_i = 1'b0; inj_en_i = 1'b1; inj_idx_i = IDX_W'(idx);
      tick();
      inj_en_i = 1'b0; data_i = d2; cap_en_i = 1'b1; late_par_i = par_of(d2) ^ m;
      tick();
      cap_en_i = 1'b0;
      chk(warn_o == m, "R9 warn", warn_o, m);
      chk(err_o == eg, "R9 err", err_o, eg);
      chk(data_o == d2, "R9 data", data_o, d2);
      tick();
      chk(warn_o == '0 && err_o == '0, "R9 both clear", {warn_o, err_o}, 0);
    end

    // R6: capture and inject on one edge
    for (int idx = 0; idx < DATA_W; idx++) begin
      d = next_word();
      data_i = d; cap_en_i = 1'b1; inj_en_i = 1'b1; inj_idx_i = IDX_W'(idx);
      late_par_i = par_of(d);
      tick();
      cap_en_i = 1'b0; inj_en_i = 1'b0;
      chk(data_o == d, "R6 capture wins", data_o, d);
      tick();
      chk(err_o == '0, "R6 no error", err_o, 0);
    end

    // R1: asynchronous reset mid-run
    data_i = 16'hA5A5; cap_en_i = 1'b1; late_par_i = '1;
    tick();
    cap_en_i = 1'b0;
    rst_ni = 1'b0;
    #3;
    chk_zero("R1 async reset");
    tick();
    chk_zero("R1 held in reset");
    rst_ni = 1'b1;
    tick();
    finish_run();
  end
endmodule